// File: doc/BRIEF.md
# Fully-Associative Translation Buffer with Page Protection

This block caches virtual-to-physical page translations in a small fully-associative store. A lookup presents a virtual page number, a page offset, an address-space identifier and an access type (read or write). In the same cycle the block reports one of three outcomes: a permitted hit with the physical address, a protection fault on an entry that matches but forbids the access, or a miss that raises a refill request toward an external page-table walker.

Each stored entry carries a valid flag, read and write permission flags, a dirty flag, the virtual page tag, the address-space tag and the physical page number. Because the address-space tag takes part in the match, translations from several contexts can live side by side, and a context switch needs no global flush. The walker writes new translations through a refill port. An invalidation port clears either every entry or only the entries of one address space. The first permitted write to a clean page sets the entry's dirty flag and pulses a notification that carries the page number, so the page table can be updated.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid, so any lookup raises `miss_req` with `lk_hit` and `lk_fault` low.
- R2: A lookup whose page number and address-space identifier both match a valid entry, with the needed permission set, drives `lk_hit` high in the same cycle and `lk_paddr` = {entry physical page, `lk_off`}.
- R3: A lookup that matches no valid entry drives `miss_req` high with `lk_hit` and `lk_fault` low. A refill written at a clock edge is visible to lookups from the next cycle on.
- R4: An entry whose address-space tag differs from `lk_asid` never matches, even when the page number is equal.
- R5: A matching read (`lk_write`=0) on an entry whose read flag is 0, or a matching write (`lk_write`=1) on an entry whose write flag is 0, drives `lk_fault` high with `lk_hit` and `miss_req` low.
- R6: A permitted write hit on an entry whose dirty flag is 0 pulses `dirty_upd` in that cycle with `dirty_vpn` = `lk_vpn`, and sets the dirty flag at the clock edge, so a later write to the same entry gives no pulse. Reads and faulting accesses never pulse it.
- R7: `fl_valid` with `fl_all`=1 invalidates every entry at the next clock edge.
- R8: `fl_valid` with `fl_all`=0 invalidates only the entries whose address-space tag equals `fl_asid`. All other entries keep translating.
- R9: A refill places the entry as follows. It overwrites a valid entry with the same page number and identifier, if one exists. Otherwise it uses the lowest-numbered invalid entry. Otherwise it uses the entry at a rotating pointer, which then advances by one modulo the entry count. The pointer is 0 after reset.
- R10: `lk_paddr` is all zeros in every cycle where `lk_hit` is low. With `lk_valid` low, all lookup outputs are low.
- R11: In one cycle the updates apply in this order: dirty set, then invalidation, then refill. A refill issued together with a flush therefore survives, and the victim is chosen from the entry state before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_off | input | OFF_W | Page offset, passed through unchanged |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| lk_hit | output | 1 | Permitted translation found |
| lk_fault | output | 1 | Entry matched but the access is not permitted |
| miss_req | output | 1 | No entry matched; refill requested |
| lk_paddr | output | PPN_W+OFF_W | Physical address on a hit, else zero |
| dirty_upd | output | 1 | First write to a clean page |
| dirty_vpn | output | VPN_W | Page number that goes with `dirty_upd` |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_asid | input | ASID_W | Refill address-space identifier |
| rf_ppn | input | PPN_W | Refill physical page number |
| rf_rd | input | 1 | Refill read permission |
| rf_wr | input | 1 | Refill write permission |
| rf_dirty | input | 1 | Refill initial dirty flag |
| fl_valid | input | 1 | Invalidation strobe |
| fl_all | input | 1 | 1: clear all entries; 0: clear by identifier |
| fl_asid | input | ASID_W | Identifier for selective invalidation |

## Verification
On every cycle the assertions check that hit, fault and miss exclude one another, that the physical address is zero without a hit, that a dirty pulse comes only with a write hit, that a global flush leaves no valid entry, that the replacement pointer only holds or steps by one, and that a repeated write right after a dirty pulse does not pulse again. Which entry a refill lands in, whether overwriting a duplicate keeps the other entries, selective invalidation by identifier, and the ordering of simultaneous flush and refill show up only in the bench's scenarios. The bench checks them there against a reference model of the entry store.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Per-entry permission and status flags
    typedef struct packed {
        logic rd;
        logic wr;
        logic dirty;
    } perm_t;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    function automatic logic access_ok(input perm_t p, input acc_e a);
        return (a == ACC_WRITE) ? p.wr : p.rd;
    endfunction

endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare: one comparator per entry on page number and space id.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] tag_asid,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tag_vpn[g] == key_vpn)
                          && (tag_asid[g] == key_asid);
    end
endmodule

// File: rtl/tlb_enc.sv
// Encodes an at-most-one-hot vector to an index plus an any flag.
module tlb_enc #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vec,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vec[i]) idx = idx | IDX_W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/tlb_victim.sv
// Refill slot choice: duplicate entry, else lowest free, else rotating pointer.
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic               dup_any,
    input  logic [IDX_W-1:0]   dup_idx,
    input  logic [IDX_W-1:0]   rptr,
    output logic [IDX_W-1:0]   slot,
    output logic               use_ptr
);
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_idx = '0;
        free_any = ~&valid;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
        if (dup_any) begin
            slot    = dup_idx;
            use_ptr = 1'b0;
        end else if (free_any) begin
            slot    = free_idx;
            use_ptr = 1'b0;
        end else begin
            slot    = rptr;
            use_ptr = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [OFF_W-1:0]  lk_off,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic              miss_req,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              dirty_upd,
    output logic [VPN_W-1:0]  dirty_vpn,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic              rf_rd,
    input  logic              rf_wr,
    input  logic              rf_dirty,
    input  logic              fl_valid,
    input  logic              fl_all,
    input  logic [ASID_W-1:0] fl_asid
);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        perm_t [ENTRIES-1:0]            perm;
        logic [IDX_W-1:0]               rptr;
    } state_t;

    state_t st_q, st_d;

    logic [ENTRIES-1:0] lk_match, rf_match;
    logic [IDX_W-1:0]   lk_idx, rf_dup_idx, rf_slot;
    logic               lk_any, rf_dup_any, rf_use_ptr;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   rptr;
    perm_t              hit_perm;
    logic               allowed;
    acc_e               acc;

    assign valid_vec = st_q.valid;
    assign rptr      = st_q.rptr;

    // Lookup-side compare
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .valid    (st_q.valid),
        .tag_vpn  (st_q.vpn),
        .tag_asid (st_q.asid),
        .key_vpn  (lk_vpn),
        .key_asid (lk_asid),
        .match    (lk_match)
    );

    tlb_enc #(.ENTRIES(ENTRIES)) u_lk_enc (
        .vec (lk_match),
        .idx (lk_idx),
        .any (lk_any)
    );

    // Refill-side compare for duplicate detection
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
        .valid    (st_q.valid),
        .tag_vpn  (st_q.vpn),
        .tag_asid (st_q.asid),
        .key_vpn  (rf_vpn),
        .key_asid (rf_asid),
        .match    (rf_match)
    );

    tlb_enc #(.ENTRIES(ENTRIES)) u_rf_enc (
        .vec (rf_match),
        .idx (rf_dup_idx),
        .any (rf_dup_any)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid   (st_q.valid),
        .dup_any (rf_dup_any),
        .dup_idx (rf_dup_idx),
        .rptr    (st_q.rptr),
        .slot    (rf_slot),
        .use_ptr (rf_use_ptr)
    );

    always_comb begin
        // ---------------- lookup results ----------------
        acc       = acc_e'(lk_write);
        hit_perm  = st_q.perm[lk_idx];
        allowed   = access_ok(hit_perm, acc);
        lk_hit    = lk_valid && lk_any && allowed;
        lk_fault  = lk_valid && lk_any && !allowed;
        miss_req  = lk_valid && !lk_any;
        lk_paddr  = lk_hit ? {st_q.ppn[lk_idx], lk_off} : '0;
        dirty_upd = lk_hit && (acc == ACC_WRITE) && !hit_perm.dirty;
        dirty_vpn = dirty_upd ? lk_vpn : '0;

        // ---------------- next state ----------------
        st_d = st_q;

        // 1: dirty marking
        if (dirty_upd) begin
            st_d.perm[lk_idx].dirty = 1'b1;
        end

        // 2: invalidation
        if (fl_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fl_all || (st_q.asid[i] == fl_asid)) begin
                    st_d.valid[i] = 1'b0;
                end
            end
        end

        // 3: refill (slot chosen from pre-flush state)
        if (rf_valid) begin
            st_d.valid[rf_slot]      = 1'b1;
            st_d.vpn[rf_slot]        = rf_vpn;
            st_d.asid[rf_slot]       = rf_asid;
            st_d.ppn[rf_slot]        = rf_ppn;
            st_d.perm[rf_slot].rd    = rf_rd;
            st_d.perm[rf_slot].wr    = rf_wr;
            st_d.perm[rf_slot].dirty = rf_dirty;
            if (rf_use_ptr) begin
                st_d.rptr = (st_q.rptr == IDX_W'(ENTRIES - 1)) ? '0
                                                               : st_q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PA_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_write,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic [ASID_W-1:0]  lk_asid,
    input logic               lk_hit,
    input logic               lk_fault,
    input logic               miss_req,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               dirty_upd,
    input logic               rf_valid,
    input logic               fl_valid,
    input logic               fl_all,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [IDX_W-1:0]   rptr
);

    p_hit_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    p_miss_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> (!lk_hit && !lk_fault && lk_valid));

    p_paddr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    p_dirty_on_write_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_upd |-> (lk_hit && lk_write));

    p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_all && !rf_valid) |=> (valid_vec == '0));

    p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr != $past(rptr)) |->
            (rptr == (($past(rptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rptr) + 1'b1)));

    p_dirty_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_upd && !fl_valid && !rf_valid) |=>
            ((lk_valid && lk_write && lk_vpn == $past(lk_vpn)
              && lk_asid == $past(lk_asid)) |-> !dirty_upd));

endmodule

bind tlb_assoc tlb_assoc_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W),
    .PA_W    (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_write  (lk_write),
    .lk_vpn    (lk_vpn),
    .lk_asid   (lk_asid),
    .lk_hit    (lk_hit),
    .lk_fault  (lk_fault),
    .miss_req  (miss_req),
    .lk_paddr  (lk_paddr),
    .dirty_upd (dirty_upd),
    .rf_valid  (rf_valid),
    .fl_valid  (fl_valid),
    .fl_all    (fl_all),
    .valid_vec (valid_vec),
    .rptr      (rptr)
);

// File: tb/tlb_assoc_test.sv
module tlb_assoc_test;
    localparam int N = 16, VW = 20, PW = 20, OW = 12, AW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0, lk_write = 0;
    logic [VW-1:0] lk_vpn = '0;
    logic [OW-1:0] lk_off = '0;
    logic [AW-1:0] lk_asid = '0;
    logic lk_hit, lk_fault, miss_req, dirty_upd;
    logic [PW+OW-1:0] lk_paddr;
    logic [VW-1:0] dirty_vpn;
    logic rf_valid = 0, rf_rd = 0, rf_wr = 0, rf_dirty = 0;
    logic [VW-1:0] rf_vpn = '0;
    logic [AW-1:0] rf_asid = '0;
    logic [PW-1:0] rf_ppn = '0;
    logic fl_valid = 0, fl_all = 0;
    logic [AW-1:0] fl_asid = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tlb_assoc uut (.*);

    // reference model
    bit          m_v[N];
    bit [VW-1:0] m_vpn[N];
    bit [AW-1:0] m_asid[N];
    bit [PW-1:0] m_ppn[N];
    bit          m_r[N], m_w[N], m_d[N];
    int          m_ptr;

    function automatic int find(input bit [VW-1:0] v, input bit [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
        return -1;
    endfunction

    task automatic check(input string tag);
        int k;
        bit eh, ef, em, ed;
        bit [PW+OW-1:0] ep;
        bit [VW-1:0] edv;
        k = find(lk_vpn, lk_asid);
        eh = 0; ef = 0; em = 0; ed = 0; ep = '0; edv = '0;
        if (lk_valid) begin
            if (k < 0) em = 1;
            else if (lk_write ? m_w[k] : m_r[k]) begin
                eh = 1; ep = {m_ppn[k], lk_off};
                if (lk_write && !m_d[k]) begin ed = 1; edv = lk_vpn; end
            end else ef = 1;
        end
        checks++;
        if ({lk_hit, lk_fault, miss_req, dirty_upd} != {eh, ef, em, ed}
            || lk_paddr != ep || dirty_vpn != edv) begin
            errors++;
            $display("FAIL %s: hit/fault/miss/dupd=%b%b%b%b paddr=%h dvpn=%h expected %b%b%b%b paddr=%h dvpn=%h",
                     tag, lk_hit, lk_fault, miss_req, dirty_upd, lk_paddr, dirty_vpn,
                     eh, ef, em, ed, ep, edv);
        end
    endtask

    task automatic model_update();
        int k, s;
        bit dup, free;
        k = find(lk_vpn, lk_asid);
        s = -1;
        if (rf_valid) begin
            s = find(rf_vpn, rf_asid);
            dup = (s >= 0);
            free = 0;
            if (!dup) for (int i = 0; i < N; i++) if (!m_v[i] && !free) begin s = i; free = 1; end
            if (!dup && !free) begin s = m_ptr; m_ptr = (m_ptr + 1) % N; end
        end
        if (lk_valid && k >= 0 && lk_write && m_w[k] && !m_d[k]) m_d[k] = 1;
        if (fl_valid) for (int i = 0; i < N; i++) if (fl_all || m_asid[i] == fl_asid) m_v[i] = 0;
        if (rf_valid) begin
            m_v[s] = 1; m_vpn[s] = rf_vpn; m_asid[s] = rf_asid; m_ppn[s] = rf_ppn;
            m_r[s] = rf_rd; m_w[s] = rf_wr; m_d[s] = rf_dirty;
        end
    endtask

    // one cycle: inputs already set after a negedge
    task automatic tick(input string tag);
        #1 check(tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        lk_valid = 0; rf_valid = 0; fl_valid = 0;
    endtask

    task automatic look(input int v, input int a, input bit wr, input string tag);
        lk_valid = 1; lk_vpn = VW'(v); lk_asid = AW'(a); lk_write = wr;
        lk_off = OW'($urandom);
        tick(tag);
    endtask

    task automatic fill(input int v, input int a, input int p, input bit r, input bit w, input bit d);
        rf_valid = 1; rf_vpn = VW'(v); rf_asid = AW'(a); rf_ppn = PW'(p);
        rf_rd = r; rf_wr = w; rf_dirty = d;
        tick("R3");
    endtask

    task automatic flush(input bit all, input int a);
        fl_valid = 1; fl_all = all; fl_asid = AW'(a);
        tick("R8");
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0;
            m_r[i] = 0; m_w[i] = 0; m_d[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        look(5, 1, 0, "R1");
        look(0, 0, 1, "R1");
        // R2 / R3: refill then hit next cycle
        fill(5, 1, 'hABCDE, 1, 1, 0);
        look(5, 1, 0, "R2");
        // R4: other address space misses
        look(5, 2, 0, "R4");
        // R6: first write pulses, second does not
        look(5, 1, 1, "R6");
        look(5, 1, 1, "R6");
        // R5: no-permission entry
        fill(6, 1, 'h11111, 0, 0, 0);
        look(6, 1, 0, "R5");
        look(6, 1, 1, "R5");
        // R9: duplicate overwrite
        fill(5, 1, 'h22222, 1, 0, 0);
        look(5, 1, 0, "R9");
        look(5, 1, 1, "R9");
        look(6, 1, 0, "R9");
        // R8: selective flush
        fill(7, 2, 'h33333, 1, 1, 1);
        flush(0, 1);
        look(5, 1, 0, "R8");
        look(7, 2, 1, "R8");
        // R7: global flush
        flush(1, 0);
        look(7, 2, 0, "R7");
        // R9: fill past capacity, rotating eviction
        for (int i = 0; i < N + 3; i++) fill(100 + i, 3, 'h40000 + i, 1, 1, 0);
        for (int i = 0; i < N + 3; i++) look(100 + i, 3, 0, "R9");
        // R11: flush with refill in the same cycle
        fl_valid = 1; fl_all = 1; rf_valid = 1; rf_vpn = 9; rf_asid = 4;
        rf_ppn = 'h55555; rf_rd = 1; rf_wr = 1; rf_dirty = 0;
        tick("R11");
        look(9, 4, 1, "R11");
        look(100, 3, 0, "R11");
        // R10: idle outputs
        tick("R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            lk_valid = ($urandom % 4) != 0;
            lk_vpn = VW'($urandom % 12); lk_asid = AW'($urandom % 3);
            lk_off = OW'($urandom); lk_write = $urandom % 2;
            rf_valid = ($urandom % 10) < 3;
            rf_vpn = VW'($urandom % 12); rf_asid = AW'($urandom % 3);
            rf_ppn = PW'($urandom); rf_rd = ($urandom % 4) != 0;
            rf_wr = $urandom % 2; rf_dirty = ($urandom % 4) == 0;
            fl_valid = ($urandom % 40) == 0; fl_all = $urandom % 2;
            fl_asid = AW'($urandom % 3);
            tick("R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule